// File: doc/BRIEF.md
# Debug-Aware Low-Power Clock Sequencer

This block steps a small core between four operating modes: run, sleep, stop and standby. It drives two clock enables. One is a free-running core clock. The other is the bus and execution clock. It also drives the clock-source select, the PLL and crystal enables, a power-down request and a system reset request. Software asks for a low-power mode through three request inputs. Any wakeup input brings the controller back to run.

A three-bit debug control register holds one override bit per low-power mode. A set bit keeps the clocks alive while the core is idle, so an attached debugger keeps working. Stop and standby exits always return the clock configuration to its reset defaults, whatever the override. A sleep exit leaves the configuration alone. A status flag records that the core came back from standby. The flag survives the standby-generated reset and is cleared by writing one to it.

The write port decodes three addresses:

| Address | Register | Bits |
|---|---|---|
| 0 | Debug control | [2] standby override, [1] stop override, [0] sleep override |
| 1 | Clock configuration | [3] PLL enable, [2] crystal enable, [1:0] source select (0 = internal RC, 1 = crystal, 2 = PLL) |
| 2 | Status | Writing 1 to bit 0 clears the standby-resume flag |

Mode codes on `mode` are: RUN = 0, SLEEP = 1, STOP = 2, STANDBY = 3.

The transitions are:
- RUN_TO_SLEEP, RUN_TO_STOP and RUN_TO_STANDBY leave run on a request.
- SLEEP_WAKE, STOP_WAKE and STANDBY_WAKE return to run on a wakeup.
- Every other case holds the current state.

All outputs are registered and change on the same edge as the state register.

Top module: `lpclk_ctrl`

## Requirements
- R1: While `por_n` is low and after its release, the block shows the reset state: mode = 0, both clock enables = 1, `clk_src` = 0, PLL and crystal enables = 0, `pwr_down` = 0, `sys_rst_req` = 0, `standby_flag` = 0, `dbg_ctrl` = 0.
- R2: From RUN, a request moves the mode on the next edge. The order of precedence is standby, then stop, then sleep.
- R3: In SLEEP with debug bit 0 clear, `fclk_en` = 1 and `hclk_en` = 0, and the source, PLL and crystal outputs keep the programmed configuration.
- R4: In SLEEP with debug bit 0 set, both clock enables are 1 and the source stays as programmed.
- R5: Leaving SLEEP leaves the clock configuration (address 1) unchanged.
- R6: In STOP with debug bit 1 clear, `fclk_en`, `hclk_en`, `pll_en` and `xtal_en` are all 0.
- R7: In STOP with debug bit 1 set, both clock enables are 1, `clk_src` = 0 (internal RC), and the PLL and crystal enables are 0.
- R8: Leaving STOP or STANDBY returns the clock configuration to `clk_src` = 0 with the PLL and crystal enables at 0. This holds for either value of the debug bits.
- R9: In STANDBY with debug bit 2 clear, `pwr_down` = 1, both clock enables are 0 and `sys_rst_req` = 0. On the wake edge `sys_rst_req` is 1 for exactly one cycle.
- R10: In STANDBY with debug bit 2 set, both clock enables are 1, `clk_src` = 0, `pwr_down` = 0 and `sys_rst_req` is held at 1. It is still 1 in the first RUN cycle and 0 after that.
- R11: `standby_flag` is set on every standby exit and stays set until a write of 1 to address 2 bit 0. A write of 0 there has no effect. A set and a clear in the same cycle leave the flag set.
- R12: Any set `wake` bit in SLEEP, STOP or STANDBY returns the mode to RUN on the next edge. `wake` is ignored in RUN, and requests are ignored outside RUN.
- R13: `dbg_ctrl` takes bits [2:0] written to address 0. Only `por_n` clears it; a standby exit does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| req_sleep | input | 1 | Request to enter sleep |
| req_stop | input | 1 | Request to enter stop |
| req_standby | input | 1 | Request to enter standby |
| wake | input | NWAKE | Wakeup events; any set bit wakes the controller |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 debug, 1 clock configuration, 2 status) |
| wr_data | input | 4 | Register write data |
| mode | output | 2 | Current mode code |
| fclk_en | output | 1 | Free-running core clock enable |
| hclk_en | output | 1 | Bus/execution clock enable |
| clk_src | output | 2 | Clock source select |
| pll_en | output | 1 | PLL enable |
| xtal_en | output | 1 | Crystal oscillator enable |
| pwr_down | output | 1 | Power-down request to the supply |
| sys_rst_req | output | 1 | System reset request |
| standby_flag | output | 1 | Resumed-from-standby status |
| dbg_ctrl | output | 3 | Debug control register value |

## Verification
The bench programs a non-default configuration (PLL source, both oscillators on) before each mode. This catches a design that clears the configuration on a sleep exit, or that keeps it after a stop or standby exit with the override set. It walks every override value through the three low-power modes. A decode that mixes up the bits, for example one that gates the wrong clock in sleep or leaves the PLL running in a debug stop, shows up on the enables.

The reset request is sampled in every standby cycle and in the cycles after wake. This exposes a pulse that is missing, held one cycle too long, or asserted when the override is clear. The bench also writes a status clear in the same cycle as a standby wake, writes a zero to the status bit, and checks that the debug register survives the standby reset. Finally it drives requests during sleep and wakes during run; a design that honours either leaves the mode off its expected code.

// File: rtl/lpclk_pkg.sv
package lpclk_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SLEEP = 2'd1,
        ST_STOP  = 2'd2,
        ST_STBY  = 2'd3
    } lp_state_e;

    localparam int DBG_W   = 3;
    localparam int SRC_W   = 2;
    localparam int ADDR_W  = 2;
    localparam int DATA_W  = 4;

    // debug override bit positions
    localparam int DBG_SLEEP = 0;
    localparam int DBG_STOP  = 1;
    localparam int DBG_STBY  = 2;

    // register addresses
    localparam logic [ADDR_W-1:0] A_DBG  = 2'd0;
    localparam logic [ADDR_W-1:0] A_CFG  = 2'd1;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd2;

    localparam logic [SRC_W-1:0] SRC_RC = 2'd0;

    typedef struct packed {
        logic             pll_on;
        logic             xtal_on;
        logic [SRC_W-1:0] src;
    } clk_cfg_t;

    localparam clk_cfg_t CFG_DEFAULT = '{pll_on: 1'b0, xtal_on: 1'b0, src: SRC_RC};

    typedef struct packed {
        logic             fclk;
        logic             hclk;
        logic [SRC_W-1:0] src;
        logic             pll;
        logic             xtal;
        logic             pdn;
        logic             rst;
    } lp_out_t;

endpackage

// File: rtl/lpclk_fsm.sv
module lpclk_fsm
    import lpclk_pkg::*;
(
    input  logic      clk,
    input  logic      por_n,
    input  logic      req_sleep,
    input  logic      req_stop,
    input  logic      req_standby,
    input  logic      wake_any,
    output lp_state_e state_q,
    output lp_state_e state_d,
    output logic      exit_deep,
    output logic      exit_stby
);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (req_standby)    state_d = ST_STBY;   // RUN_TO_STANDBY
                else if (req_stop)  state_d = ST_STOP;   // RUN_TO_STOP
                else if (req_sleep) state_d = ST_SLEEP;  // RUN_TO_SLEEP
            end
            ST_SLEEP, ST_STOP, ST_STBY: begin
                if (wake_any) state_d = ST_RUN;          // *_WAKE
            end
            default: state_d = ST_RUN;
        endcase
    end

    assign exit_deep = wake_any && (state_q == ST_STOP || state_q == ST_STBY);
    assign exit_stby = wake_any && (state_q == ST_STBY);

endmodule

// File: rtl/lpclk_regs.sv
module lpclk_regs
    import lpclk_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              exit_deep,
    input  logic              exit_stby,
    output logic [DBG_W-1:0]  dbg_q,
    output logic [DBG_W-1:0]  dbg_d,
    output clk_cfg_t          cfg_d,
    output logic              flag_q
);

    clk_cfg_t cfg_q;
    logic     flag_d;
    logic     wr_dbg, wr_cfg, wr_clr;

    assign wr_dbg = wr_en && (wr_addr == A_DBG);
    assign wr_cfg = wr_en && (wr_addr == A_CFG);
    assign wr_clr = wr_en && (wr_addr == A_STAT) && wr_data[0];

    always_comb begin
        dbg_d = dbg_q;
        if (wr_dbg) dbg_d = wr_data[DBG_W-1:0];
    end

    // a deep-mode exit overrides any write in the same cycle
    always_comb begin
        cfg_d = cfg_q;
        if (wr_cfg)    cfg_d = clk_cfg_t'(wr_data);
        if (exit_deep) cfg_d = CFG_DEFAULT;
    end

    // set has precedence over the write-one-to-clear
    always_comb begin
        flag_d = flag_q;
        if (wr_clr)    flag_d = 1'b0;
        if (exit_stby) flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            dbg_q  <= '0;
            cfg_q  <= CFG_DEFAULT;
            flag_q <= 1'b0;
        end else begin
            dbg_q  <= dbg_d;
            cfg_q  <= cfg_d;
            flag_q <= flag_d;
        end
    end

endmodule

// File: rtl/lpclk_outdec.sv
module lpclk_outdec
    import lpclk_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  lp_state_e        state_d,
    input  logic             exit_stby,
    input  logic [DBG_W-1:0] dbg_d,
    input  clk_cfg_t         cfg_d,
    output lp_out_t          out_q
);

    localparam lp_out_t OUT_RESET = '{fclk: 1'b1, hclk: 1'b1, src: SRC_RC,
                                      pll: 1'b0, xtal: 1'b0, pdn: 1'b0, rst: 1'b0};

    lp_out_t out_d;

    always_comb begin
        out_d = OUT_RESET;
        unique case (state_d)
            ST_RUN: begin
                out_d.src  = cfg_d.src;
                out_d.pll  = cfg_d.pll_on;
                out_d.xtal = cfg_d.xtal_on;
                out_d.rst  = exit_stby;
            end
            ST_SLEEP: begin
                out_d.hclk = dbg_d[DBG_SLEEP];
                out_d.src  = cfg_d.src;
                out_d.pll  = cfg_d.pll_on;
                out_d.xtal = cfg_d.xtal_on;
            end
            ST_STOP: begin
                out_d.fclk = dbg_d[DBG_STOP];
                out_d.hclk = dbg_d[DBG_STOP];
            end
            ST_STBY: begin
                out_d.fclk = dbg_d[DBG_STBY];
                out_d.hclk = dbg_d[DBG_STBY];
                out_d.pdn  = !dbg_d[DBG_STBY];
                out_d.rst  = dbg_d[DBG_STBY];
            end
            default: out_d = OUT_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) out_q <= OUT_RESET;
        else        out_q <= out_d;
    end

endmodule

// File: rtl/lpclk_ctrl.sv
module lpclk_ctrl
    import lpclk_pkg::*;
#(
    parameter int NWAKE = 4
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              req_sleep,
    input  logic              req_stop,
    input  logic              req_standby,
    input  logic [NWAKE-1:0]  wake,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [1:0]        mode,
    output logic              fclk_en,
    output logic              hclk_en,
    output logic [SRC_W-1:0]  clk_src,
    output logic              pll_en,
    output logic              xtal_en,
    output logic              pwr_down,
    output logic              sys_rst_req,
    output logic              standby_flag,
    output logic [DBG_W-1:0]  dbg_ctrl
);

    lp_state_e        st_q, st_d;
    logic             ex_deep, ex_stby;
    logic [DBG_W-1:0] dbg_nx;
    clk_cfg_t         cfg_nx;
    lp_out_t          outs;

    lpclk_fsm u_fsm (
        .clk        (clk),
        .por_n      (por_n),
        .req_sleep  (req_sleep),
        .req_stop   (req_stop),
        .req_standby(req_standby),
        .wake_any   (|wake),
        .state_q    (st_q),
        .state_d    (st_d),
        .exit_deep  (ex_deep),
        .exit_stby  (ex_stby)
    );

    lpclk_regs u_regs (
        .clk      (clk),
        .por_n    (por_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .exit_deep(ex_deep),
        .exit_stby(ex_stby),
        .dbg_q    (dbg_ctrl),
        .dbg_d    (dbg_nx),
        .cfg_d    (cfg_nx),
        .flag_q   (standby_flag)
    );

    lpclk_outdec u_out (
        .clk      (clk),
        .por_n    (por_n),
        .state_d  (st_d),
        .exit_stby(ex_stby),
        .dbg_d    (dbg_nx),
        .cfg_d    (cfg_nx),
        .out_q    (outs)
    );

    assign mode        = st_q;
    assign fclk_en     = outs.fclk;
    assign hclk_en     = outs.hclk;
    assign clk_src     = outs.src;
    assign pll_en      = outs.pll;
    assign xtal_en     = outs.xtal;
    assign pwr_down    = outs.pdn;
    assign sys_rst_req = outs.rst;

endmodule

// File: rtl/lpclk_chk.sv
module lpclk_chk #(
    parameter int NWAKE = 4
) (
    input logic             clk,
    input logic             por_n,
    input logic             req_sleep,
    input logic             req_stop,
    input logic             req_standby,
    input logic [NWAKE-1:0] wake,
    input logic [1:0]       mode,
    input logic             fclk_en,
    input logic             hclk_en,
    input logic [1:0]       clk_src,
    input logic             pll_en,
    input logic             xtal_en,
    input logic             pwr_down,
    input logic             sys_rst_req,
    input logic             standby_flag,
    input logic [2:0]       dbg_ctrl
);

    // R2
    run_to_standby_chk: assert property (@(posedge clk) disable iff (!por_n)
        (mode == 2'd0 && req_standby) |=> (mode == 2'd3));

    // R2
    run_to_stop_chk: assert property (@(posedge clk) disable iff (!por_n)
        (mode == 2'd0 && !req_standby && req_stop) |=> (mode == 2'd2));

    // R3
    sleep_gate_chk: assert property (@(posedge clk) disable iff (!por_n)
        (mode == 2'd1 && !dbg_ctrl[0]) |-> (fclk_en && !hclk_en));

    // R6
    stop_all_off_chk: assert property (@(posedge clk) disable iff (!por_n)
        (mode == 2'd2 && !dbg_ctrl[1]) |-> (!fclk_en && !hclk_en && !pll_en && !xtal_en));

    // R7
    stop_debug_rc_chk: assert property (@(posedge clk) disable iff (!por_n)
        (mode == 2'd2 && dbg_ctrl[1]) |-> (fclk_en && hclk_en && clk_src == 2'd0));

    // R8
    deep_exit_default_chk: assert property (@(posedge clk) disable iff (!por_n)
        (mode[1] && (|wake)) |=> (clk_src == 2'd0 && !pll_en && !xtal_en));

    // R9
    standby_pdn_chk: assert property (@(posedge clk) disable iff (!por_n)
        (mode == 2'd3 && !dbg_ctrl[2]) |-> (pwr_down && !fclk_en && !sys_rst_req));

    // R10
    standby_rst_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (mode == 2'd3 && dbg_ctrl[2]) |-> (sys_rst_req && !pwr_down));

    // R11
    standby_flag_set_chk: assert property (@(posedge clk) disable iff (!por_n)
        (mode == 2'd3 && (|wake)) |=> (standby_flag && sys_rst_req));

    // R12
    wake_return_chk: assert property (@(posedge clk) disable iff (!por_n)
        (mode != 2'd0 && (|wake)) |=> (mode == 2'd0));

    // R12
    sleep_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (mode == 2'd1 && !(|wake)) |=> (mode == 2'd1));

endmodule

bind lpclk_ctrl lpclk_chk #(.NWAKE(NWAKE)) u_chk (
    .clk         (clk),
    .por_n       (por_n),
    .req_sleep   (req_sleep),
    .req_stop    (req_stop),
    .req_standby (req_standby),
    .wake        (wake),
    .mode        (mode),
    .fclk_en     (fclk_en),
    .hclk_en     (hclk_en),
    .clk_src     (clk_src),
    .pll_en      (pll_en),
    .xtal_en     (xtal_en),
    .pwr_down    (pwr_down),
    .sys_rst_req (sys_rst_req),
    .standby_flag(standby_flag),
    .dbg_ctrl    (dbg_ctrl)
);

// File: tb/sim_lpclk_ctrl.sv
`timescale 1ns/1ps
module sim_lpclk_ctrl;

    localparam int NW = 4;

    logic          clk = 1'b0;
    logic          por_n;
    logic          req_sleep, req_stop, req_standby;
    logic [NW-1:0] wake;
    logic          wr_en;
    logic [1:0]    wr_addr;
    logic [3:0]    wr_data;
    logic [1:0]    mode;
    logic          fclk_en, hclk_en, pll_en, xtal_en, pwr_down, sys_rst_req, standby_flag;
    logic [1:0]    clk_src;
    logic [2:0]    dbg_ctrl;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    lpclk_ctrl #(.NWAKE(NW)) u0 (
        .clk(clk), .por_n(por_n), .req_sleep(req_sleep), .req_stop(req_stop),
        .req_standby(req_standby), .wake(wake), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .mode(mode), .fclk_en(fclk_en), .hclk_en(hclk_en),
        .clk_src(clk_src), .pll_en(pll_en), .xtal_en(xtal_en), .pwr_down(pwr_down),
        .sys_rst_req(sys_rst_req), .standby_flag(standby_flag), .dbg_ctrl(dbg_ctrl)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [3:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic request(input logic sl, input logic st, input logic sb);
        req_sleep = sl; req_stop = st; req_standby = sb;
        tick();
        req_sleep = 1'b0; req_stop = 1'b0; req_standby = 1'b0;
    endtask

    task automatic wake_up(input logic [NW-1:0] w);
        wake = w;
        tick();
        wake = '0;
    endtask

    task automatic t_reset();
        chk("R1 mode", mode, 0);
        chk("R1 fclk", fclk_en, 1);
        chk("R1 hclk", hclk_en, 1);
        chk("R1 src", clk_src, 0);
        chk("R1 pll", pll_en, 0);
        chk("R1 xtal", xtal_en, 0);
        chk("R1 pdn", pwr_down, 0);
        chk("R1 rst", sys_rst_req, 0);
        chk("R1 flag", standby_flag, 0);
        chk("R1 dbg", dbg_ctrl, 0);
    endtask

    task automatic t_sleep();
        wr(2'd0, 4'b0000);
        wr(2'd1, 4'b1110);
        chk("R5 cfg src run", clk_src, 2);
        request(1'b1, 1'b0, 1'b0);
        chk("R2 mode sleep", mode, 1);
        chk("R3 fclk", fclk_en, 1);
        chk("R3 hclk", hclk_en, 0);
        chk("R3 src kept", clk_src, 2);
        chk("R3 pll kept", pll_en, 1);
        request(1'b0, 1'b1, 1'b0);
        chk("R12 req ignored in sleep", mode, 1);
        wake_up(4'b0100);
        chk("R12 wake to run", mode, 0);
        chk("R5 src after sleep", clk_src, 2);
        chk("R5 pll after sleep", pll_en, 1);
        chk("R5 xtal after sleep", xtal_en, 1);
        wr(2'd0, 4'b0001);
        request(1'b1, 1'b0, 1'b0);
        chk("R4 fclk", fclk_en, 1);
        chk("R4 hclk", hclk_en, 1);
        chk("R4 src", clk_src, 2);
        wake_up(4'b0001);
        chk("R4 back to run", mode, 0);
    endtask

    task automatic t_stop();
        wr(2'd0, 4'b0000);
        wr(2'd1, 4'b1110);
        request(1'b1, 1'b1, 1'b0);
        chk("R2 stop over sleep", mode, 2);
        chk("R6 fclk", fclk_en, 0);
        chk("R6 hclk", hclk_en, 0);
        chk("R6 pll", pll_en, 0);
        chk("R6 xtal", xtal_en, 0);
        tick();
        chk("R6 still stop", mode, 2);
        wake_up(4'b1000);
        chk("R8 src after stop", clk_src, 0);
        chk("R8 pll after stop", pll_en, 0);
        chk("R8 xtal after stop", xtal_en, 0);
        chk("R8 clocks on", fclk_en & hclk_en, 1);
        wr(2'd0, 4'b0010);
        wr(2'd1, 4'b1110);
        request(1'b0, 1'b1, 1'b0);
        chk("R7 fclk", fclk_en, 1);
        chk("R7 hclk", hclk_en, 1);
        chk("R7 src rc", clk_src, 0);
        chk("R7 pll off", pll_en, 0);
        wake_up(4'b0010);
        chk("R8 dbg stop src", clk_src, 0);
        chk("R8 dbg stop pll", pll_en, 0);
        chk("R8 dbg stop xtal", xtal_en, 0);
        chk("R12 mode run", mode, 0);
    endtask

    task automatic t_standby_nodbg();
        wr(2'd0, 4'b0000);
        wr(2'd1, 4'b1101);
        request(1'b1, 1'b1, 1'b1);
        chk("R2 standby wins", mode, 3);
        chk("R9 pdn", pwr_down, 1);
        chk("R9 fclk", fclk_en, 0);
        chk("R9 hclk", hclk_en, 0);
        chk("R9 rst low", sys_rst_req, 0);
        wake_up(4'b0001);
        chk("R9 rst pulse", sys_rst_req, 1);
        chk("R9 pdn released", pwr_down, 0);
        chk("R11 flag set", standby_flag, 1);
        chk("R8 standby src", clk_src, 0);
        chk("R8 standby pll", pll_en, 0);
        tick();
        chk("R9 rst one cycle", sys_rst_req, 0);
        wr(2'd2, 4'b0000);
        chk("R11 zero write keeps", standby_flag, 1);
        wr(2'd2, 4'b0001);
        chk("R11 w1c clears", standby_flag, 0);
    endtask

    task automatic t_standby_dbg();
        wr(2'd0, 4'b0100);
        wr(2'd1, 4'b1110);
        request(1'b0, 1'b0, 1'b1);
        chk("R10 fclk", fclk_en, 1);
        chk("R10 hclk", hclk_en, 1);
        chk("R10 src rc", clk_src, 0);
        chk("R10 pdn", pwr_down, 0);
        chk("R10 rst", sys_rst_req, 1);
        tick();
        chk("R10 rst held", sys_rst_req, 1);
        wake = 4'b0010;
        wr(2'd2, 4'b0001);
        wake = '0;
        chk("R10 rst on wake", sys_rst_req, 1);
        chk("R11 set wins", standby_flag, 1);
        chk("R13 dbg survives", dbg_ctrl, 4);
        chk("R8 dbg standby pll", pll_en, 0);
        tick();
        chk("R10 rst drops", sys_rst_req, 0);
        chk("R11 flag stays", standby_flag, 1);
    endtask

    task automatic t_run_wake();
        wake_up(4'b1111);
        chk("R12 wake in run", mode, 0);
        chk("R12 run clocks", fclk_en & hclk_en, 1);
        wr(2'd0, 4'b0101);
        chk("R13 dbg write", dbg_ctrl, 5);
    endtask

    initial begin
        por_n = 1'b0;
        req_sleep = 1'b0; req_stop = 1'b0; req_standby = 1'b0;
        wake = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        tick();
        tick();
        t_reset();
        por_n = 1'b1;
        tick();
        t_reset();
        t_sleep();
        t_stop();
        t_standby_nodbg();
        t_standby_dbg();
        t_run_wake();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R12 watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule